// File: doc/BRIEF.md
# Package Sleep Cache-Way Controller

This block moves a multi-core package into and out of its deepest sleep state. The package may sleep only once the shared last-level cache holds nothing. So when every core reports the deepest core sleep state, the controller shrinks the cache group by group. It asks an external flush engine to write back each group of ways, and it drops those ways from the enabled set once the engine confirms. When the last way is gone, the package-sleep flag rises. Snoops are blocked for as long as that flag is high, because the package then holds no data that a snoop could find.

Any core leaving the deepest state ends package sleep or stops a shrink in progress. The cache is not refilled at once. The controller first waits for a programmable number of cycles in which no core sits in either of the two deepest core states. It then re-enables one way per programmable interval until every way is back. The number of ways flushed per step is sampled from an input each time a shrink sequence begins.

Enabled ways always form a contiguous run starting at way 0. Shrinking removes ways from the top of that run, and growing adds them back at the top.

Top module: `pkg_sleep_way_ctrl`

## Requirements
- R1: `pkg_sleep_o` rises only on the clock edge after a cycle in which every bit of `core_deep_i` is 1. While it is high, `ways_en_o` is all zeros.
- R2: While shrinking, `flush_req_o` is high and `flush_mask_o` selects the highest-numbered enabled ways. On the edge where `flush_done_i` is sampled high together with the request, exactly those bits clear in `ways_en_o`. `ways_en_o` never loses ways at any other time.
- R3: The step size is taken from `step_i` on the edge that starts a shrink sequence. Later changes to `step_i` do not affect the size of the groups in that sequence.
- R4: `snoop_block_o` is high exactly when `pkg_sleep_o` is high. Both fall on the first edge after any `core_deep_i` bit goes low while the package sleeps.
- R5: A `step_i` of 0 acts as 1. The last group is clipped to the ways still enabled, so a step of s on 8 ways gives ceil(8/max(s,1)) groups.
- R6: If any core does not report the deepest state, no flush is requested and `ways_en_o` stays all ones.
- R7: If a core wakes during a shrink, the pending group still completes on `flush_done_i`. Shrinking then stops, the flushed ways stay disabled, `pkg_sleep_o` never rises, and the regrow path later restores them.
- R8: After exit, `ways_en_o` stays zero until `resid_delay_i`+1 consecutive cycles pass in which no bit of `core_deep_i` or `core_mid_i` is set. With D = `resid_delay_i` and I = `grow_intv_i`, the first way returns D+I+3 edges after the edge on which cores leave sleep. Any set bit in either input restarts the count.
- R9: During regrow, `ways_en_o` gains exactly one way (the next higher index) every I+1 cycles. It reaches all ones D+2+8(I+1) edges after the wake edge for 8 ways, and a new shrink may then begin.
- R10: After reset, `ways_en_o` is all ones and `flush_req_o`, `pkg_sleep_o` and `snoop_block_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_deep_i | input | NUM_CORES | Per core: in the deepest core sleep state |
| core_mid_i | input | NUM_CORES | Per core: in the second-deepest core sleep state |
| step_i | input | $clog2(NUM_WAYS+1) | Ways flushed per group, sampled at shrink entry |
| flush_done_i | input | 1 | Flush engine has finished the requested group |
| resid_delay_i | input | TMR_W | Residency delay before regrow |
| grow_intv_i | input | TMR_W | Regrow interval, one way per grow_intv_i+1 cycles |
| ways_en_o | output | NUM_WAYS | Enabled-ways mask |
| flush_req_o | output | 1 | Flush of `flush_mask_o` requested |
| flush_mask_o | output | NUM_WAYS | Ways in the group being flushed |
| pkg_sleep_o | output | 1 | Package is in deep sleep |
| snoop_block_o | output | 1 | Snoops to the package are blocked |

## Verification
The hardest situation to reach is a core waking while a group flush is still outstanding. The bench reaches it by holding back its flush-done response for several cycles on the third group, then dropping one core's deep-sleep bit before answering. A related condition is a residency count cut short by a single-cycle excursion into the second-deepest state. The bench forces that with a one-cycle `core_mid_i` pulse partway through the wait, then times the first regrown way from the pulse.

// File: rtl/psw_pkg.sv
// Shared types for the package sleep cache-way controller.
// Assumes: none beyond a single clock domain.
package psw_pkg;
    typedef enum logic [2:0] {
        ST_ACTIVE    = 3'd0,
        ST_SHRINK    = 3'd1,
        ST_PKG_SLEEP = 3'd2,
        ST_EXIT_WAIT = 3'd3,
        ST_GROW      = 3'd4
    } psw_state_e;
endpackage

// File: rtl/psw_interval_timer.sv
// Cycle counter that reports when it has counted 'limit' enabled cycles.
// hit is high in the enabled cycle whose count equals limit; the count then
// restarts. Assumes: clr has priority over counting.
module psw_interval_timer #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [TMR_W-1:0] limit,
    output logic             hit
);
    logic [TMR_W-1:0] cnt_q;

    assign hit = en && (cnt_q == limit);

    // Count enabled cycles, restart on clear or on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (clr || hit) cnt_q <= '0;
        else if (en)         cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/psw_way_mask.sv
// Turns an enabled-way count into the enabled mask and the next flush group.
// Enabled ways are the low en_cnt ways; the group is the top min(step, en_cnt)
// of them. Assumes: en_cnt <= NUM_WAYS and step >= 1 while a group is used.
module psw_way_mask #(
    parameter int NUM_WAYS = 8,
    parameter int CW       = $clog2(NUM_WAYS + 1)
) (
    input  logic [CW-1:0]       en_cnt,
    input  logic [CW-1:0]       step,
    output logic [NUM_WAYS-1:0] ways_en,
    output logic [NUM_WAYS-1:0] grp_mask,
    output logic [CW-1:0]       grp_size
);
    logic [CW-1:0] lo_idx;

    // Clip the group to the ways still enabled.
    always_comb begin
        grp_size = (step < en_cnt) ? step : en_cnt;
        lo_idx   = en_cnt - grp_size;
    end

    for (genvar i = 0; i < NUM_WAYS; i++) begin : g_way
        assign ways_en[i]  = (CW'(i) < en_cnt);
        assign grp_mask[i] = (CW'(i) < en_cnt) && (CW'(i) >= lo_idx);
    end
endmodule

// File: rtl/pkg_sleep_way_ctrl.sv
// Package deep-sleep sequencer with progressive cache-way shrink and delayed,
// gradual regrow. Flush datapath and cache arrays are external; flush_done_i
// acknowledges the group shown on flush_mask_o while flush_req_o is high.
// Assumes: enabled ways are always the contiguous low ways.
module pkg_sleep_way_ctrl #(
    parameter int NUM_CORES = 4,
    parameter int NUM_WAYS  = 8,
    parameter int TMR_W     = 8,
    localparam int SW       = $clog2(NUM_WAYS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CORES-1:0] core_deep_i,
    input  logic [NUM_CORES-1:0] core_mid_i,
    input  logic [SW-1:0]        step_i,
    input  logic                 flush_done_i,
    input  logic [TMR_W-1:0]     resid_delay_i,
    input  logic [TMR_W-1:0]     grow_intv_i,
    output logic [NUM_WAYS-1:0]  ways_en_o,
    output logic                 flush_req_o,
    output logic [NUM_WAYS-1:0]  flush_mask_o,
    output logic                 pkg_sleep_o,
    output logic                 snoop_block_o
);
    import psw_pkg::*;

    localparam logic [SW-1:0] FULL_CNT = SW'(NUM_WAYS);

    psw_state_e    state_q, state_d;
    logic [SW-1:0] en_cnt_q, en_cnt_d;
    logic [SW-1:0] step_q, step_d;
    logic [SW-1:0] grp_size;
    logic [SW-1:0] step_eff;
    logic          all_deep, quiet, res_hit, grow_hit;

    assign all_deep = &core_deep_i;
    assign quiet    = ~|(core_deep_i | core_mid_i);
    assign step_eff = (step_i == '0) ? SW'(1) : step_i;

    psw_way_mask #(.NUM_WAYS(NUM_WAYS), .CW(SW)) u_mask (
        .en_cnt  (en_cnt_q),
        .step    (step_q),
        .ways_en (ways_en_o),
        .grp_mask(flush_mask_o),
        .grp_size(grp_size)
    );

    psw_interval_timer #(.TMR_W(TMR_W)) u_resid (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  ((state_q != ST_EXIT_WAIT) || !quiet),
        .en   ((state_q == ST_EXIT_WAIT) && quiet),
        .limit(resid_delay_i),
        .hit  (res_hit)
    );

    psw_interval_timer #(.TMR_W(TMR_W)) u_grow (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state_q != ST_GROW),
        .en   (state_q == ST_GROW),
        .limit(grow_intv_i),
        .hit  (grow_hit)
    );

    assign flush_req_o   = (state_q == ST_SHRINK);
    assign pkg_sleep_o   = (state_q == ST_PKG_SLEEP);
    assign snoop_block_o = (state_q == ST_PKG_SLEEP);

    // Next-state, way-count and step selection.
    always_comb begin
        state_d  = state_q;
        en_cnt_d = en_cnt_q;
        step_d   = step_q;
        unique case (state_q)
            ST_SHRINK: begin
                if (flush_done_i) begin
                    en_cnt_d = en_cnt_q - grp_size;
                    if (!all_deep)              state_d = ST_EXIT_WAIT;
                    else if (en_cnt_d == '0)    state_d = ST_PKG_SLEEP;
                end
            end
            ST_PKG_SLEEP: begin
                if (!all_deep) state_d = ST_EXIT_WAIT;
            end
            default: begin
                if (all_deep) begin
                    step_d  = step_eff;
                    state_d = (en_cnt_q == '0) ? ST_PKG_SLEEP : ST_SHRINK;
                end else if (state_q == ST_EXIT_WAIT && res_hit) begin
                    state_d = (en_cnt_q == FULL_CNT) ? ST_ACTIVE : ST_GROW;
                end else if (state_q == ST_GROW && grow_hit && en_cnt_q != FULL_CNT) begin
                    en_cnt_d = en_cnt_q + 1'b1;
                    if (en_cnt_d == FULL_CNT) state_d = ST_ACTIVE;
                end
            end
        endcase
    end

    // State registers; reset assumes every way is populated and enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_ACTIVE;
            en_cnt_q <= FULL_CNT;
            step_q   <= SW'(1);
        end else begin
            state_q  <= state_d;
            en_cnt_q <= en_cnt_d;
            step_q   <= step_d;
        end
    end

    AST_SLEEP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pkg_sleep_o |-> (ways_en_o == '0)); // R1
    AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pkg_sleep_o) |-> $past(&core_deep_i)); // R1
    AST_SHRINK_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(ways_en_o) < $countones($past(ways_en_o))) |-> $past(flush_req_o && flush_done_i)); // R2
    AST_GROUP_IN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req_o |-> ((flush_mask_o != '0) && ((flush_mask_o & ~ways_en_o) == '0))); // R2
    AST_STEP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req_o && $past(flush_req_o)) |-> $stable(step_q)); // R3
    AST_SNOOP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_block_o |-> (!flush_req_o && ways_en_o == '0)); // R4
    AST_GROUP_CLIP: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req_o |-> (step_q != '0 && $countones(flush_mask_o) <= int'(step_q))); // R5
    AST_NO_GROW_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXIT_WAIT && !quiet) |=> $stable(ways_en_o)); // R8
    AST_GROW_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(ways_en_o) > $countones($past(ways_en_o)))
        |-> ($countones(ways_en_o) == $countones($past(ways_en_o)) + 1)); // R9
endmodule

// File: tb/sim_pkg_sleep_way_ctrl.sv
module sim_pkg_sleep_way_ctrl;
    localparam int NC = 4;
    localparam int NW = 8;
    localparam int TW = 8;
    localparam int SW = $clog2(NW + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] core_deep_i = '0;
    logic [NC-1:0] core_mid_i = '0;
    logic [SW-1:0] step_i = '0;
    logic          flush_done_i = 1'b0;
    logic [TW-1:0] resid_delay_i = '0;
    logic [TW-1:0] grow_intv_i = '0;
    logic [NW-1:0] ways_en_o, flush_mask_o;
    logic          flush_req_o, pkg_sleep_o, snoop_block_o;

    int errors = 0;
    int checks = 0;
    bit sleep_seen = 0;
    bit req_seen = 0;

    always #5 clk = ~clk;

    pkg_sleep_way_ctrl #(.NUM_CORES(NC), .NUM_WAYS(NW), .TMR_W(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .core_deep_i(core_deep_i), .core_mid_i(core_mid_i),
        .step_i(step_i), .flush_done_i(flush_done_i), .resid_delay_i(resid_delay_i),
        .grow_intv_i(grow_intv_i), .ways_en_o(ways_en_o), .flush_req_o(flush_req_o),
        .flush_mask_o(flush_mask_o), .pkg_sleep_o(pkg_sleep_o), .snoop_block_o(snoop_block_o)
    );

    always @(negedge clk) begin
        if (pkg_sleep_o) sleep_seen = 1;
        if (flush_req_o) req_seen = 1;
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [NW-1:0] low_mask(input int n);
        return NW'((64'd1 << n) - 1);
    endfunction

    // Enter sleep with step s, answer each flush after lat cycles.
    task automatic run_shrink(input int s, input int lat);
        int k = (s == 0) ? 1 : s;
        int rem = NW;
        int groups = 0;
        int g;
        @(negedge clk);
        core_deep_i = '1;
        step_i = SW'(s);
        for (int guard = 0; guard < 400 && !pkg_sleep_o; guard++) begin
            @(negedge clk);
            if (flush_req_o) begin
                step_i = SW'(s ^ 5);  // R3: later changes must be ignored
                repeat (lat) @(negedge clk);
                g = (k < rem) ? k : rem;
                chk("R2/R3/R5 group mask", flush_mask_o, low_mask(rem) & ~low_mask(rem - g));
                chk("R2 enabled before group", ways_en_o, low_mask(rem));
                rem -= g;
                groups++;
                flush_done_i = 1'b1;
                @(negedge clk);
                flush_done_i = 1'b0;
            end
        end
        chk("R5 group count", groups, (NW + k - 1) / k);
        chk("R1 sleep flag", pkg_sleep_o, 1);
        chk("R1 ways empty", ways_en_o, 0);
        chk("R4 snoop block in sleep", snoop_block_o, 1);
    endtask

    // Wake from sleep and time the regrow.
    task automatic run_wake(input int d, input int iv);
        int n_first = -1;
        int n_full = -1;
        int prev = 0;
        resid_delay_i = TW'(d);
        grow_intv_i = TW'(iv);
        @(negedge clk);
        core_deep_i = '0;
        core_mid_i = '0;
        for (int n = 1; n < 600 && n_full < 0; n++) begin
            @(posedge clk);
            #1;
            if (n == 1) begin
                chk("R4 sleep falls on wake edge", pkg_sleep_o, 0);
                chk("R4 snoop falls on wake edge", snoop_block_o, 0);
            end
            if ($countones(ways_en_o) != prev) begin
                chk("R9 one way per step", $countones(ways_en_o), prev + 1);
                chk("R9 contiguous low ways", ways_en_o, low_mask($countones(ways_en_o)));
                prev = $countones(ways_en_o);
                if (n_first < 0) n_first = n;
                if (prev == NW) n_full = n;
            end
        end
        chk("R8 first way timing", n_first, d + iv + 3);
        chk("R9 full timing", n_full, d + 2 + NW * (iv + 1));
    endtask

    initial begin
        int dl [4] = '{0, 1, 3, 5};
        int n_first;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset ways", ways_en_o, low_mask(NW));
        chk("R10 reset req", flush_req_o, 0);
        chk("R10 reset sleep", pkg_sleep_o, 0);
        chk("R10 reset snoop", snoop_block_o, 0);

        // R6: one core only in the second-deepest state.
        core_deep_i = 4'b0111;
        core_mid_i = 4'b1000;
        step_i = 2;
        req_seen = 0;
        repeat (20) @(negedge clk);
        chk("R6 no flush when not all deep", req_seen, 0);
        chk("R6 ways stay full", ways_en_o, low_mask(NW));
        core_deep_i = '0;
        core_mid_i = '0;

        // Sweep every step value with several delays and intervals.
        for (int s = 0; s < 16; s++) begin
            run_shrink(s, s % 3);
            run_wake(dl[s % 4], s % 3);
        end

        // R8 restart: a one-cycle mid-state excursion during the wait.
        run_shrink(3, 1);
        resid_delay_i = 4;
        grow_intv_i = 1;
        @(negedge clk);
        core_deep_i = '0;
        repeat (3) @(negedge clk);
        core_mid_i = 4'b0100;
        @(negedge clk);
        core_mid_i = '0;
        n_first = -1;
        for (int n = 1; n < 200 && n_first < 0; n++) begin
            @(posedge clk);
            #1;
            if (ways_en_o != 0) n_first = n;
        end
        chk("R8 count restarts after mid pulse", n_first, 4 + 1 + 2);
        for (int guard = 0; guard < 200 && ways_en_o != low_mask(NW); guard++) @(negedge clk);
        chk("R9 regrow completes", ways_en_o, low_mask(NW));

        // R7: wake while the third group flush is still outstanding.
        resid_delay_i = 2;
        grow_intv_i = 0;
        sleep_seen = 0;
        @(negedge clk);
        core_deep_i = '1;
        step_i = 1;
        for (int grp = 0; grp < 2; grp++) begin
            for (int guard = 0; guard < 50 && !flush_req_o; guard++) @(negedge clk);
            flush_done_i = 1'b1;
            @(negedge clk);
            flush_done_i = 1'b0;
        end
        repeat (2) @(negedge clk);
        core_deep_i = 4'b1011;
        @(negedge clk);
        chk("R7 request held after wake", flush_req_o, 1);
        chk("R7 pending group", flush_mask_o, 8'h20);
        flush_done_i = 1'b1;
        @(negedge clk);
        flush_done_i = 1'b0;
        chk("R7 group cleared", ways_en_o, 8'h1F);
        chk("R7 shrink stopped", flush_req_o, 0);
        core_deep_i = '0;
        for (int guard = 0; guard < 200 && ways_en_o != low_mask(NW); guard++) @(negedge clk);
        chk("R7 never slept", sleep_seen, 0);
        chk("R7 ways restored", ways_en_o, low_mask(NW));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule